// File: doc/BRIEF.md
# Serial Wire Debug Register Transaction Engine

This block is the host side of a two-wire debug link. It takes one request at a time from a local command queue: an 8-bit request header, a 32-bit write value and a post-access idle count for access-port operations. It runs the complete bus frame on a generated serial clock and a bidirectional data line, split into a data-out, a data-in and an output-enable. Reads return 32 bits of captured data. Every request, whether it reaches the bus or not, returns one response carrying a status code.

The engine handles the frame on its own. It drives the header, hands the line to the target for the turnaround and acknowledge bits, then either captures the read word and its parity or drives the write word and its parity. It interprets the acknowledge. When the target asks the host to wait, the engine first sends a write to the debug-port abort register that clears the sticky flags, then repeats the original frame. The first failure is kept as a held status. Later requests are answered from it without any bus traffic until a flush request clocks eight idle cycles, reports the held status and clears it.

Top module: `swd_txn_engine`

## Requirements
- R1: While the engine is idle the serial clock is low and the line is driven low. Each frame begins with the 8 header bits, driven least significant bit first, with bit 0 (start) and bit 7 (park) forced to 1 whatever the request holds.
- R2: A read (header bit 2 = 1) releases the line (output-enable low) for 38 bit times: 1 turnaround, 3 acknowledge, 32 data, 1 parity, 1 turnaround. A frame is 46 clocks in all. The data is captured least significant bit first and returned on rsp_rdata with status 2'b00. rsp_rdata is zero for writes, failures and skipped requests.
- R3: A write (header bit 2 = 0) releases the line for 5 bit times (turnaround, 3 acknowledge, turnaround). It then drives the 32 write bits least significant bit first, followed by one parity bit equal to the XOR of those bits.
- R4: Each half of the serial clock lasts HALF_CYC system clocks. The line output and output-enable change only while the serial clock is low. The input is sampled in the last system clock before the rising edge.
- R5: On an acknowledge of WAIT (3'b010), the engine sends a write frame with header 8'h81 and data 32'h0000_001E, which sets the abort bits 1 to 4. It then repeats the original frame from its header.
- R6: Acknowledge bits arrive least significant bit first. An acknowledge of FAULT (3'b100) gives status 2'b01. Any value other than OK (3'b001), WAIT or FAULT gives status 2'b10.
- R7: Once a failure status is held, each later non-flush request is answered with that status and zero data, without a single serial clock edge.
- R8: If a read's parity bit differs from the XOR of its 32 data bits, the status is 2'b11 and the data returned is zero.
- R9: After a successful access-port access (header bit 1 = 1), the engine clocks req_delay extra bit times with the line released. Debug-port accesses and failed accesses get no extra bit times.
- R10: For a write to debug-port address 0xC (header bits 1 and 2 both 0, bits 4:3 = 2'b11), the acknowledge is ignored. Such a write always completes with status 2'b00 in one frame, with no retry.
- R11: A flush request clocks 8 bit times with the line driven low, responds with the held status, and clears it to 2'b00.
- R12: req_ready is high only while idle, and each accepted request produces exactly one rsp_valid pulse, issued while returning to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting |
| req_flush | input | 1 | Request is a flush instead of an access |
| req_cmd | input | 8 | Request header |
| req_wdata | input | 32 | Write value |
| req_delay | input | DLY_W | Idle bit times after a successful access-port access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 ok, 01 fault, 10 protocol error, 11 parity error |
| rsp_rdata | output | 32 | Read data, zero otherwise |
| swclk | output | 1 | Serial clock |
| swdio_out | output | 1 | Line value when driven |
| swdio_oe | output | 1 | Host drives the line when high |
| swdio_in | input | 1 | Line value as seen at the pad |

## Verification
The bench builds the engine with HALF_CYC = 2, so the sampling cycle is separate from the rising-edge cycle. A target model that changes its output right after each rising edge then exposes a host that samples one cycle late. DLY_W = 4 keeps the access-port idle windows short. It still allows delays of 3 to 7 bit times, whose exact clock counts the bench measures per response, alongside the released-line bit counts that tell reads, writes, flushes and skipped requests apart.

// File: rtl/swd_txn_pkg.sv
// Shared types and constants for the serial debug transaction engine.
// Assumes a 32-bit data word and a 3-bit acknowledge, as the wire format requires.
package swd_txn_pkg;

    localparam int WORD_W   = 32;
    localparam int HDR_W    = 8;
    localparam int ACK_W    = 3;
    localparam int IDLE_LEN = 8;

    // Header bit positions the engine decodes
    localparam int HB_START = 0;
    localparam int HB_AP    = 1;
    localparam int HB_RNW   = 2;
    localparam int HB_A2    = 3;
    localparam int HB_A3    = 4;
    localparam int HB_PARK  = 7;

    localparam logic [HDR_W-1:0]  FORCE_MASK  = 8'h81;
    localparam logic [HDR_W-1:0]  ABORT_HDR   = 8'h81;
    localparam logic [WORD_W-1:0] ABORT_CLEAR = 32'h0000_001E;

    localparam logic [ACK_W-1:0] ACK_GOOD  = 3'b001;
    localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [3:0] {
        PH_IDLE, PH_HDR, PH_TRN_A, PH_ACK, PH_RDATA, PH_RPAR,
        PH_TRN_B, PH_WDATA, PH_WPAR, PH_EVAL, PH_APDLY, PH_FLUSH
    } phase_t;

    typedef enum logic [1:0] {
        STS_OK = 2'b00, STS_FAULT = 2'b01, STS_PROTO = 2'b10, STS_PARITY = 2'b11
    } status_t;

    typedef enum logic [2:0] {
        V_DONE, V_RETRY, V_FAULT, V_JUNK, V_BADPAR
    } verdict_t;

endpackage

// File: rtl/swd_bit_timer.sv
// Serial clock generator: splits each bit time into a low half and a high half
// of HALF_CYC system clocks each. It runs only while run_i is high and parks low otherwise.
// Assumes run_i changes only on a bit boundary (counter at zero).
module swd_bit_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic swclk_o,
    output logic sample_o,
    output logic bit_end_o
);
    localparam int PER = 2 * HALF_CYC;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(PER - 1);
    localparam logic [CW-1:0] SAMP_CNT = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] HIGH_CNT = CW'(HALF_CYC);

    logic [CW-1:0] cnt_q;

    // Phase counter within one bit time
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            cnt_q <= '0;
        else if (cnt_q == LAST_CNT)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign swclk_o   = (cnt_q >= HIGH_CNT);
    assign sample_o  = run_i && (cnt_q == SAMP_CNT);
    assign bit_end_o = run_i && (cnt_q == LAST_CNT);

endmodule

// File: rtl/swd_line_drive.sv
// Output mux for the data line: picks the value and enable from the current phase.
// Assumes phase and bit select come from registers that only change on bit boundaries.
module swd_line_drive
    import swd_txn_pkg::*;
(
    input  phase_t              phase_i,
    input  logic [4:0]          bit_sel_i,
    input  logic [HDR_W-1:0]    hdr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic                out_o,
    output logic                oe_o
);
    // Drive value and enable per phase
    always_comb begin
        out_o = 1'b0;
        oe_o  = 1'b0;
        unique case (phase_i)
            PH_IDLE, PH_EVAL, PH_FLUSH: oe_o = 1'b1;
            PH_HDR: begin
                oe_o  = 1'b1;
                out_o = hdr_i[bit_sel_i[2:0]];
            end
            PH_WDATA: begin
                oe_o  = 1'b1;
                out_o = wdata_i[bit_sel_i];
            end
            PH_WPAR: begin
                oe_o  = 1'b1;
                out_o = ^wdata_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/swd_resp_check.sv
// Classifies a finished frame from its acknowledge, read data and parity bit.
// Assumes ack_i holds the acknowledge with its first received bit at position 0.
module swd_resp_check
    import swd_txn_pkg::*;
(
    input  logic [ACK_W-1:0]  ack_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              par_i,
    input  logic              is_read_i,
    input  logic              ack_ignored_i,
    output verdict_t          verdict_o
);
    // Decode the acknowledge, then check read parity on success
    always_comb begin
        if (ack_ignored_i)
            verdict_o = V_DONE;
        else begin
            unique case (ack_i)
                ACK_GOOD:  verdict_o = (is_read_i && ((^data_i) != par_i)) ? V_BADPAR : V_DONE;
                ACK_WAIT:  verdict_o = V_RETRY;
                ACK_FAULT: verdict_o = V_FAULT;
                default:   verdict_o = V_JUNK;
            endcase
        end
    end

endmodule

// File: rtl/swd_txn_engine.sv
// Host-side debug register transaction engine: runs one header/acknowledge/data
// frame per request. It retries WAIT after an abort write, holds the first failure,
// and answers held failures without bus traffic until a flush.
// Assumes one request in flight; the target answers on the line released by swdio_oe.
module swd_txn_engine
    import swd_txn_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int DLY_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_flush,
    input  logic [7:0]        req_cmd,
    input  logic [31:0]       req_wdata,
    input  logic [DLY_W-1:0]  req_delay,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [31:0]       rsp_rdata,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    localparam int CNT_W = (DLY_W > 6) ? DLY_W : 6;

    phase_t             phase_q;
    logic [CNT_W-1:0]   bit_idx_q;
    logic [HDR_W-1:0]   hdr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic [DLY_W-1:0]   dly_q;
    logic               abort_q;
    logic [ACK_W-1:0]   ack_q;
    logic [WORD_W-1:0]  rx_q;
    logic               rxpar_q;
    status_t            err_q;

    logic [HDR_W-1:0]   bus_hdr;
    logic [WORD_W-1:0]  bus_wdata;
    logic               is_read;
    logic               ack_ignored;
    logic               run;
    logic               sample;
    logic               bit_end;
    logic [CNT_W-1:0]   phase_len;
    logic               last_bit;
    verdict_t           verdict;

    // Header and data on the bus: the abort frame replaces the request while active
    always_comb begin
        bus_hdr   = abort_q ? ABORT_HDR : hdr_q;
        bus_wdata = abort_q ? ABORT_CLEAR : wdata_q;
    end

    assign is_read     = bus_hdr[HB_RNW];
    assign ack_ignored = !bus_hdr[HB_AP] && !bus_hdr[HB_RNW] && bus_hdr[HB_A3] && bus_hdr[HB_A2];
    assign run         = (phase_q != PH_IDLE) && (phase_q != PH_EVAL);
    assign req_ready   = (phase_q == PH_IDLE);

    swd_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .swclk_o   (swclk),
        .sample_o  (sample),
        .bit_end_o (bit_end)
    );

    swd_line_drive u_drive (
        .phase_i   (phase_q),
        .bit_sel_i (bit_idx_q[4:0]),
        .hdr_i     (bus_hdr),
        .wdata_i   (bus_wdata),
        .out_o     (swdio_out),
        .oe_o      (swdio_oe)
    );

    swd_resp_check u_check (
        .ack_i         (ack_q),
        .data_i        (rx_q),
        .par_i         (rxpar_q),
        .is_read_i     (is_read),
        .ack_ignored_i (ack_ignored),
        .verdict_o     (verdict)
    );

    // Number of bit times in the current phase
    always_comb begin
        unique case (phase_q)
            PH_HDR, PH_FLUSH:   phase_len = CNT_W'(IDLE_LEN);
            PH_ACK:             phase_len = CNT_W'(ACK_W);
            PH_RDATA, PH_WDATA: phase_len = CNT_W'(WORD_W);
            PH_APDLY:           phase_len = CNT_W'(dly_q);
            default:            phase_len = CNT_W'(1);
        endcase
    end

    assign last_bit = (bit_idx_q == phase_len - 1'b1);

    // Capture acknowledge, read data and parity just before the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= '0;
            rx_q    <= '0;
            rxpar_q <= 1'b0;
        end else if (sample) begin
            if (phase_q == PH_ACK)   ack_q   <= {swdio_in, ack_q[ACK_W-1:1]};
            if (phase_q == PH_RDATA) rx_q    <= {swdio_in, rx_q[WORD_W-1:1]};
            if (phase_q == PH_RPAR)  rxpar_q <= swdio_in;
        end
    end

    // Frame sequencing, retry, held status and responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            bit_idx_q  <= '0;
            hdr_q      <= '0;
            wdata_q    <= '0;
            dly_q      <= '0;
            abort_q    <= 1'b0;
            err_q      <= STS_OK;
            rsp_valid  <= 1'b0;
            rsp_status <= STS_OK;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (req_valid) begin
                    bit_idx_q <= '0;
                    if (req_flush)
                        phase_q <= PH_FLUSH;
                    else if (err_q != STS_OK) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= err_q;
                        rsp_rdata  <= '0;
                    end else begin
                        hdr_q   <= req_cmd | FORCE_MASK;
                        wdata_q <= req_wdata;
                        dly_q   <= req_delay;
                        abort_q <= 1'b0;
                        phase_q <= PH_HDR;
                    end
                end
            end else if (phase_q == PH_EVAL) begin
                bit_idx_q <= '0;
                unique case (verdict)
                    V_RETRY: begin
                        abort_q <= 1'b1;
                        phase_q <= PH_HDR;
                    end
                    V_DONE: begin
                        if (abort_q) begin
                            abort_q <= 1'b0;
                            phase_q <= PH_HDR;
                        end else if (hdr_q[HB_AP] && (dly_q != '0)) begin
                            phase_q <= PH_APDLY;
                        end else begin
                            phase_q    <= PH_IDLE;
                            rsp_valid  <= 1'b1;
                            rsp_status <= STS_OK;
                            rsp_rdata  <= is_read ? rx_q : '0;
                        end
                    end
                    default: begin
                        status_t bad;
                        bad = (verdict == V_FAULT) ? STS_FAULT :
                              (verdict == V_BADPAR) ? STS_PARITY : STS_PROTO;
                        err_q      <= bad;
                        abort_q    <= 1'b0;
                        phase_q    <= PH_IDLE;
                        rsp_valid  <= 1'b1;
                        rsp_status <= bad;
                        rsp_rdata  <= '0;
                    end
                endcase
            end else if (bit_end) begin
                bit_idx_q <= last_bit ? '0 : bit_idx_q + 1'b1;
                if (last_bit) begin
                    unique case (phase_q)
                        PH_HDR:   phase_q <= PH_TRN_A;
                        PH_TRN_A: phase_q <= PH_ACK;
                        PH_ACK:   phase_q <= is_read ? PH_RDATA : PH_TRN_B;
                        PH_RDATA: phase_q <= PH_RPAR;
                        PH_RPAR:  phase_q <= PH_TRN_B;
                        PH_TRN_B: phase_q <= is_read ? PH_EVAL : PH_WDATA;
                        PH_WDATA: phase_q <= PH_WPAR;
                        PH_WPAR:  phase_q <= PH_EVAL;
                        PH_APDLY: begin
                            phase_q    <= PH_IDLE;
                            rsp_valid  <= 1'b1;
                            rsp_status <= STS_OK;
                            rsp_rdata  <= is_read ? rx_q : '0;
                        end
                        PH_FLUSH: begin
                            phase_q    <= PH_IDLE;
                            rsp_valid  <= 1'b1;
                            rsp_status <= err_q;
                            rsp_rdata  <= '0;
                            err_q      <= STS_OK;
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/swd_txn_checker.sv
// Property checker for the transaction engine, attached to it by bind below.
// Assumes held_err is the engine's held failure status.
module swd_txn_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_flush,
    input logic       rsp_valid,
    input logic [1:0] rsp_status,
    input logic [31:0] rsp_rdata,
    input logic       swclk,
    input logic       swdio_out,
    input logic       swdio_oe,
    input logic [1:0] held_err
);
    // R1: idle means clock low and line driven
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!swclk && swdio_oe));

    // R4: line only changes while the clock is low
    p_line_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

    // R8: parity failures return no data
    p_parity_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b11) |-> (rsp_rdata == 32'h0));

    // R7: a skipped request produces no clock activity
    p_skip_no_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_flush && held_err != 2'b00) |=> (req_ready && !swclk));

    // R12: responses only on the way back to idle
    p_resp_at_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

endmodule

bind swd_txn_engine swd_txn_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_flush  (req_flush),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .swclk      (swclk),
    .swdio_out  (swdio_out),
    .swdio_oe   (swdio_oe),
    .held_err   (err_q)
);

// File: tb/tb_swd_txn_engine.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected responses, a monitor compares them,
// and a target model answers on the line and records what the host drove.
module tb_swd_txn_engine;
    localparam int HALF = 2;
    localparam int DW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_flush = 1'b0;
    logic [7:0] req_cmd = '0;
    logic [31:0] req_wdata = '0;
    logic [DW-1:0] req_delay = '0;
    logic req_ready, rsp_valid, swclk, swdio_out, swdio_oe;
    logic [1:0] rsp_status;
    logic [31:0] rsp_rdata;
    logic swdio_in = 1'b0;

    always #4 clk = ~clk;

    swd_txn_engine #(.HALF_CYC(HALF), .DLY_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_flush(req_flush), .req_cmd(req_cmd), .req_wdata(req_wdata),
        .req_delay(req_delay), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .swclk(swclk), .swdio_out(swdio_out),
        .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    typedef struct { logic [1:0] st; logic [31:0] rd; int edges; int rel; string tag; } exp_t;
    typedef struct { logic [2:0] ack; logic [31:0] rd; bit bad; } tcfg_t;
    typedef struct { logic [7:0] hdr; logic [31:0] wd; logic wp; } obs_t;

    exp_t  exp_q[$];
    tcfg_t tcfg_q[$];
    obs_t  obs_q[$];
    int checks = 0, fails = 0;
    int edge_total = 0, rel_total = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] mk(bit ap, bit rnw, logic [1:0] a);
        return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
    endfunction

    task automatic tgt(logic [2:0] ack, logic [31:0] rd, bit bad);
        tcfg_t c;
        c.ack = ack; c.rd = rd; c.bad = bad;
        tcfg_q.push_back(c);
    endtask

    // Edge counters: all rising edges, and those with the line released
    initial forever begin
        @(posedge swclk);
        edge_total++;
        if (!swdio_oe) rel_total++;
    end

    // Target model: outputs change right after each rising edge
    initial forever begin
        @(posedge swclk);
        if (swdio_oe && swdio_out) begin
            obs_t o;
            tcfg_t c;
            logic [7:0] hdr;
            hdr = 8'h01;
            o.wd = '0; o.wp = 1'b0;
            if (tcfg_q.size() != 0) c = tcfg_q.pop_front();
            else begin c.ack = 3'b001; c.rd = '0; c.bad = 1'b0; end
            for (int k = 2; k <= 46; k++) begin
                logic v;
                v = 1'b0;
                if (k >= 10 && k <= 12) v = c.ack[k-10];
                else if (hdr[2] && k >= 13 && k <= 44) v = c.rd[k-13];
                else if (hdr[2] && k == 45) v = (^c.rd) ^ c.bad;
                swdio_in = v;
                @(posedge swclk);
                if (k <= 8) hdr[k-1] = swdio_out;
                if (!hdr[2] && k >= 14 && k <= 45) o.wd[k-14] = swdio_out;
                if (!hdr[2] && k == 46) o.wp = swdio_out;
            end
            swdio_in = 1'b0;
            o.hdr = hdr;
            obs_q.push_back(o);
        end
    end

    // Monitor: compare each response against the scoreboard
    initial begin
        int e_snap = 0, r_snap = 0;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R12", "unexpected response", 32'h1, 32'h0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_status == e.st, e.tag, "status", 32'(rsp_status), 32'(e.st));
                    chk(rsp_rdata == e.rd, e.tag, "rdata", rsp_rdata, e.rd);
                    chk(edge_total - e_snap == e.edges, e.tag, "clock edges",
                        32'(edge_total - e_snap), 32'(e.edges));
                    chk(rel_total - r_snap == e.rel, e.tag, "released bits",
                        32'(rel_total - r_snap), 32'(e.rel));
                end
                e_snap = edge_total;
                r_snap = rel_total;
            end
        end
    end

    task automatic issue(bit fl, logic [7:0] cmd, logic [31:0] wd, logic [DW-1:0] dly,
                         logic [1:0] st, logic [31:0] rd, int edges, int rel, string tag);
        exp_t e;
        e.st = st; e.rd = rd; e.edges = edges; e.rel = rel; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_flush = fl; req_cmd = cmd; req_wdata = wd; req_delay = dly;
        @(negedge clk);
        req_valid = 1'b0; req_flush = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic obs_hdr(logic [7:0] hdr, string tag);
        obs_t o;
        if (obs_q.size() == 0) begin chk(1'b0, tag, "missing frame", 32'h0, 32'(hdr)); return; end
        o = obs_q.pop_front();
        chk(o.hdr == hdr, tag, "header on line", 32'(o.hdr), 32'(hdr));
    endtask

    task automatic obs_wr(logic [7:0] hdr, logic [31:0] wd, string tag);
        obs_t o;
        if (obs_q.size() == 0) begin chk(1'b0, tag, "missing frame", 32'h0, 32'(hdr)); return; end
        o = obs_q.pop_front();
        chk(o.hdr == hdr, tag, "header on line", 32'(o.hdr), 32'(hdr));
        chk(o.wd == wd, tag, "write data on line", o.wd, wd);
        chk(o.wp == ^wd, tag, "write parity", 32'(o.wp), 32'(^wd));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 R1: reset state
        chk(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R12", "no response after reset", 32'(rsp_valid), 32'h0);
        chk(swclk == 1'b0 && swdio_oe == 1'b1, "R1", "idle line", {30'h0, swclk, swdio_oe}, 32'h1);

        // R2: debug-port read
        tgt(3'b001, 32'h1234_5678, 1'b0);
        issue(1'b0, mk(0, 1, 2'b00), '0, '0, 2'b00, 32'h1234_5678, 46, 38, "R2");
        obs_hdr(mk(0, 1, 2'b00), "R1");

        // R3: debug-port write
        tgt(3'b001, '0, 1'b0);
        issue(1'b0, mk(0, 0, 2'b01), 32'hA5A5_0F0F, '0, 2'b00, '0, 46, 5, "R3");
        obs_wr(mk(0, 0, 2'b01), 32'hA5A5_0F0F, "R3");

        // R1: start and park bits forced
        tgt(3'b001, 32'h0000_0001, 1'b0);
        issue(1'b0, mk(0, 1, 2'b10) & 8'h7E, '0, '0, 2'b00, 32'h0000_0001, 46, 38, "R1");
        obs_hdr(mk(0, 1, 2'b10), "R1");

        // R9 R4: access-port read and write with idle tails
        tgt(3'b001, 32'hCAFE_F00D, 1'b0);
        issue(1'b0, mk(1, 1, 2'b00), '0, 4'd5, 2'b00, 32'hCAFE_F00D, 51, 43, "R9");
        obs_hdr(mk(1, 1, 2'b00), "R4");
        tgt(3'b001, '0, 1'b0);
        issue(1'b0, mk(1, 0, 2'b11), 32'h8000_0001, 4'd3, 2'b00, '0, 49, 8, "R9");
        obs_wr(mk(1, 0, 2'b11), 32'h8000_0001, "R9");
        tgt(3'b001, 32'h0F0F_F0F0, 1'b0);
        issue(1'b0, mk(0, 1, 2'b11), '0, 4'd7, 2'b00, 32'h0F0F_F0F0, 46, 38, "R9");
        obs_hdr(mk(0, 1, 2'b11), "R9");

        // R5: WAIT then abort then retry
        tgt(3'b010, '0, 1'b0);
        tgt(3'b001, '0, 1'b0);
        tgt(3'b001, 32'hDEAD_BEEF, 1'b0);
        issue(1'b0, mk(0, 1, 2'b01), '0, '0, 2'b00, 32'hDEAD_BEEF, 138, 81, "R5");
        obs_hdr(mk(0, 1, 2'b01), "R5");
        obs_wr(8'h81, 32'h0000_001E, "R5");
        obs_hdr(mk(0, 1, 2'b01), "R5");

        // R10: target-select write ignores FAULT and WAIT
        tgt(3'b100, '0, 1'b0);
        issue(1'b0, mk(0, 0, 2'b11), 32'h0123_4567, '0, 2'b00, '0, 46, 5, "R10");
        obs_wr(mk(0, 0, 2'b11), 32'h0123_4567, "R10");
        tgt(3'b010, '0, 1'b0);
        issue(1'b0, mk(0, 0, 2'b11), 32'h7654_3210, '0, 2'b00, '0, 46, 5, "R10");
        obs_wr(mk(0, 0, 2'b11), 32'h7654_3210, "R10");

        // R8 R7 R11: parity error, skip, flush, recover
        tgt(3'b001, 32'h5555_AAAA, 1'b1);
        issue(1'b0, mk(0, 1, 2'b00), '0, '0, 2'b11, '0, 46, 38, "R8");
        obs_hdr(mk(0, 1, 2'b00), "R8");
        issue(1'b0, mk(0, 1, 2'b00), '0, '0, 2'b11, '0, 0, 0, "R7");
        chk(obs_q.size() == 0, "R7", "no frame while held", 32'(obs_q.size()), 32'h0);
        issue(1'b1, '0, '0, '0, 2'b11, '0, 8, 0, "R11");
        tgt(3'b001, 32'h0000_BEEF, 1'b0);
        issue(1'b0, mk(0, 1, 2'b00), '0, '0, 2'b00, 32'h0000_BEEF, 46, 38, "R11");
        obs_hdr(mk(0, 1, 2'b00), "R11");

        // R6: FAULT, skip of a write, double flush
        tgt(3'b100, 32'h1111_1111, 1'b0);
        issue(1'b0, mk(0, 1, 2'b10), '0, '0, 2'b01, '0, 46, 38, "R6");
        obs_hdr(mk(0, 1, 2'b10), "R6");
        issue(1'b0, mk(0, 0, 2'b10), 32'h2222_2222, '0, 2'b01, '0, 0, 0, "R7");
        issue(1'b1, '0, '0, '0, 2'b01, '0, 8, 0, "R11");
        issue(1'b1, '0, '0, '0, 2'b00, '0, 8, 0, "R11");

        // R6: junk acknowledge
        tgt(3'b111, 32'h3333_3333, 1'b0);
        issue(1'b0, mk(0, 1, 2'b01), '0, '0, 2'b10, '0, 46, 38, "R6");
        obs_hdr(mk(0, 1, 2'b01), "R6");
        issue(1'b1, '0, '0, '0, 2'b10, '0, 8, 0, "R11");

        // R9: failed access-port access gets no idle tail
        tgt(3'b100, '0, 1'b0);
        issue(1'b0, mk(1, 1, 2'b01), '0, 4'd4, 2'b01, '0, 46, 38, "R9");
        obs_hdr(mk(1, 1, 2'b01), "R9");
        issue(1'b1, '0, '0, '0, 2'b01, '0, 8, 0, "R11");

        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1 && swclk == 1'b0, "R12", "idle at end", {30'h0, req_ready, swclk}, 32'h2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule